// File: doc/BRIEF.md
# Multichannel Sample Frame Packer

The block takes a snapshot of eight signed analog channel values together with a free-running timestamp and sends that snapshot out as a frame of four tagged words on a valid/ready stream. A pulse on the sample strobe copies the timestamp and all channels into holding registers, so every word of the frame describes the same instant. The frame then leaves one word per accepted handshake. Each word carries a tag in its upper bits, so a receiver that reads words in groups of four can tell what each word holds.

The first word holds the timestamp under a four-bit zero tag. The next three words each hold a group of channels under a two-bit tag in the upper lane. A strobe that arrives while a frame is still being sent is dropped, never restarting or splitting the frame, and a saturating counter records how many strobes were lost this way.

The controller is a five-state machine. The states are ST_IDLE, ST_TS (timestamp word on the output), ST_G1, ST_G2 and ST_G3 (channel-group words). The transitions are: ST_IDLE to ST_TS on a strobe; ST_TS to ST_G1, ST_G1 to ST_G2 and ST_G2 to ST_G3 on a handshake; ST_G3 to ST_IDLE on a handshake. Every state holds when there is no handshake.

Top module: `frame_packer`

## Requirements
- R1: After a synchronous reset (rst high), fr_valid is 0 and overrun_cnt is 0.
- R2: A strobe sampled in the idle state makes fr_valid rise after that clock edge. The first word is {4'b0000, ts[59:0]}, so the top four timestamp bits are discarded.
- R3: The second word is {2'b01, 14'b0, ch0, ch1, ch2}, with ch0 in bits 47:32, ch1 in bits 31:16 and ch2 in bits 15:0. Channel k enters ch_in at bits 16k+15:16k.
- R4: The third word is {2'b10, 14'b0, ch3, ch4, ch5}, laid out across the lanes in the same way as R3.
- R5: The fourth word is {2'b11, 14'b0, ch6, ch7, 16'h0000}, so its lowest lane is zero.
- R6: The words leave in the order R2, R3, R4, R5. A word advances only on a cycle where fr_valid and fr_ready are both high, and fr_data stays stable while fr_valid is high and fr_ready is low.
- R7: Each frame has exactly four words. After the fourth handshake, fr_valid is low until the next accepted strobe.
- R8: The channel and timestamp values are captured on the accepted strobe. Changes on ch_in and ts_in during the frame do not reach the words.
- R9: A strobe sampled in any state other than idle, including the cycle of the fourth handshake, is dropped. It increments overrun_cnt by one and leaves the frame in flight unchanged.
- R10: overrun_cnt saturates at its all-ones value.
- R11: A strobe in the first idle cycle after a frame ends is accepted, so frames can follow each other with a single idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_strobe | input | 1 | Request to capture and send a snapshot |
| ts_in | input | TS_W (64) | Free-running timestamp |
| ch_in | input | 8*LANE_W (128) | Eight channel values, channel k in bits 16k+15:16k |
| fr_valid | output | 1 | A frame word is on fr_data |
| fr_ready | input | 1 | The receiver takes the word this cycle |
| fr_data | output | 4*LANE_W (64) | Frame word |
| overrun_cnt | output | CNT_W (8) | Saturating count of dropped strobes |

## Verification
The bench keeps LANE_W at 16 and TS_W at 64, so the word layout it checks is exactly the 64-bit frame described above. It narrows CNT_W to 3, which lets a short burst of strobes during a stalled frame drive the drop counter to its all-ones value of 7 and show that it stays there. It also covers a strobe landing on the final handshake and a restart in the very next cycle.

// File: rtl/fp_pkg.sv
package fp_pkg;

    // Frame controller states, one per word on the output plus idle
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_TS   = 3'd1,
        ST_G1   = 3'd2,
        ST_G2   = 3'd3,
        ST_G3   = 3'd4
    } fp_state_e;

    localparam int NUM_CH      = 8;   // channels per snapshot
    localparam int LANES       = 4;   // lanes per output word
    localparam int NUM_GROUPS  = 3;   // channel-group words per frame
    localparam int SLOTS       = 3;   // channel slots per group word
    localparam int TS_TAG_W    = 4;   // zero tag width on the timestamp word
    localparam int GRP_TAG_W   = 2;   // tag width on group words

endpackage

// File: rtl/fp_capture.sv
module fp_capture
    import fp_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int TS_W   = 64,
    localparam int WORD_W  = LANES * LANE_W,
    localparam int TS_KEEP = WORD_W - TS_TAG_W,
    localparam int CH_W    = NUM_CH * LANE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [TS_W-1:0]    ts_in,
    input  logic [CH_W-1:0]    ch_in,
    output logic [TS_KEEP-1:0] ts_q,
    output logic [CH_W-1:0]    ch_q
);

    // Upper timestamp bits never reach the frame
    logic ts_hi_unused;
    assign ts_hi_unused = ^ts_in[TS_W-1:TS_KEEP];

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_q <= '0;
            ch_q <= '0;
        end else if (load) begin
            ts_q <= ts_in[TS_KEEP-1:0];
            ch_q <= ch_in;
        end
    end

endmodule

// File: rtl/fp_word_mux.sv
module fp_word_mux
    import fp_pkg::*;
#(
    parameter int LANE_W = 16,
    localparam int WORD_W  = LANES * LANE_W,
    localparam int TS_KEEP = WORD_W - TS_TAG_W,
    localparam int CH_W    = NUM_CH * LANE_W
) (
    input  fp_state_e          state,
    input  logic [TS_KEEP-1:0] ts_q,
    input  logic [CH_W-1:0]    ch_q,
    output logic [WORD_W-1:0]  word
);

    logic [WORD_W-1:0]                  ts_word;
    logic [NUM_GROUPS-1:0][WORD_W-1:0]  grp_word;

    assign ts_word = {{TS_TAG_W{1'b0}}, ts_q};

    // Group g holds channels SLOTS*g .. SLOTS*g+SLOTS-1, first channel in
    // the lane just below the tag lane; slots past the last channel are zero.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp_word[g][WORD_W-1 -: LANE_W] =
            {GRP_TAG_W'(g + 1), {(LANE_W - GRP_TAG_W){1'b0}}};
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            localparam int CH_IDX = SLOTS * g + s;
            localparam int TOP    = (SLOTS - s) * LANE_W - 1;
            if (CH_IDX < NUM_CH) begin : g_used
                assign grp_word[g][TOP -: LANE_W] = ch_q[CH_IDX*LANE_W +: LANE_W];
            end else begin : g_pad
                assign grp_word[g][TOP -: LANE_W] = '0;
            end
        end
    end

    always_comb begin
        word = '0;
        unique case (state)
            ST_IDLE: word = '0;
            ST_TS:   word = ts_word;
            ST_G1:   word = grp_word[0];
            ST_G2:   word = grp_word[1];
            ST_G3:   word = grp_word[2];
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/fp_drop_ctr.sv
module fp_drop_ctr #(
    parameter int CNT_W = 8,
    localparam logic [CNT_W-1:0] CNT_MAX = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fp_ctrl.sv
module fp_ctrl
    import fp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe,
    input  logic      ready,
    output fp_state_e state,
    output logic      valid,
    output logic      load,
    output logic      drop
);

    fp_state_e st_q, st_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Next state
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: if (strobe) st_nxt = ST_TS;
            ST_TS:   if (ready)  st_nxt = ST_G1;
            ST_G1:   if (ready)  st_nxt = ST_G2;
            ST_G2:   if (ready)  st_nxt = ST_G3;
            ST_G3:   if (ready)  st_nxt = ST_IDLE;
            default:             st_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        valid = 1'b0;
        load  = 1'b0;
        drop  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                load = strobe;
            end
            ST_TS, ST_G1, ST_G2, ST_G3: begin
                valid = 1'b1;
                drop  = strobe;
            end
            default: begin
                valid = 1'b0;
            end
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/frame_packer.sv
module frame_packer
    import fp_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int TS_W   = 64,
    parameter int CNT_W  = 8,
    localparam int WORD_W  = LANES * LANE_W,
    localparam int TS_KEEP = WORD_W - TS_TAG_W,
    localparam int CH_W    = NUM_CH * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_strobe,
    input  logic [TS_W-1:0]   ts_in,
    input  logic [CH_W-1:0]   ch_in,
    output logic              fr_valid,
    input  logic              fr_ready,
    output logic [WORD_W-1:0] fr_data,
    output logic [CNT_W-1:0]  overrun_cnt
);

    fp_state_e          state;
    logic               load;
    logic               drop;
    logic [TS_KEEP-1:0] ts_q;
    logic [CH_W-1:0]    ch_q;

    fp_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .strobe (sample_strobe),
        .ready  (fr_ready),
        .state  (state),
        .valid  (fr_valid),
        .load   (load),
        .drop   (drop)
    );

    fp_capture #(.LANE_W(LANE_W), .TS_W(TS_W)) u_capture (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .ts_in (ts_in),
        .ch_in (ch_in),
        .ts_q  (ts_q),
        .ch_q  (ch_q)
    );

    fp_word_mux #(.LANE_W(LANE_W)) u_mux (
        .state (state),
        .ts_q  (ts_q),
        .ch_q  (ch_q),
        .word  (fr_data)
    );

    fp_drop_ctr #(.CNT_W(CNT_W)) u_drop (
        .clk (clk),
        .rst (rst),
        .inc (drop),
        .cnt (overrun_cnt)
    );

endmodule

// File: rtl/frame_packer_chk.sv
module frame_packer_chk #(
    parameter int LANE_W = 16,
    parameter int CNT_W  = 8,
    localparam int WORD_W = 4 * LANE_W,
    localparam logic [CNT_W-1:0] CNT_MAX = '1
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_strobe,
    input logic              fr_valid,
    input logic              fr_ready,
    input logic [WORD_W-1:0] fr_data,
    input logic [CNT_W-1:0]  overrun_cnt
);

    logic [1:0] tag;
    assign tag = fr_data[WORD_W-1 -: 2];

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!fr_valid && overrun_cnt == '0));

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (sample_strobe && !fr_valid) |=> (fr_valid && fr_data[WORD_W-1 -: 4] == 4'h0));

    p_ts_to_g1_r3: assert property (@(posedge clk) disable iff (rst)
        (fr_valid && fr_ready && tag == 2'b00) |=> (fr_valid && tag == 2'b01));

    p_g1_to_g2_r4: assert property (@(posedge clk) disable iff (rst)
        (fr_valid && fr_ready && tag == 2'b01) |=> (fr_valid && tag == 2'b10));

    p_g2_to_g3_r5: assert property (@(posedge clk) disable iff (rst)
        (fr_valid && fr_ready && tag == 2'b10) |=> (fr_valid && tag == 2'b11));

    p_last_lane_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (fr_valid && tag == 2'b11) |-> (fr_data[LANE_W-1:0] == '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (fr_valid && !fr_ready) |=> (fr_valid && $stable(fr_data)));

    p_frame_end_r7: assert property (@(posedge clk) disable iff (rst)
        (fr_valid && fr_ready && tag == 2'b11) |=> !fr_valid);

    p_drop_count_r9: assert property (@(posedge clk) disable iff (rst)
        (sample_strobe && fr_valid && overrun_cnt != CNT_MAX)
            |=> (overrun_cnt == $past(overrun_cnt) + 1'b1));

    p_no_spurious_drop_r9: assert property (@(posedge clk) disable iff (rst)
        !(sample_strobe && fr_valid) |=> $stable(overrun_cnt));

    p_saturate_r10: assert property (@(posedge clk) disable iff (rst)
        (overrun_cnt == CNT_MAX) |=> (overrun_cnt == CNT_MAX));

endmodule

bind frame_packer frame_packer_chk #(.LANE_W(LANE_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sample_strobe (sample_strobe),
    .fr_valid      (fr_valid),
    .fr_ready      (fr_ready),
    .fr_data       (fr_data),
    .overrun_cnt   (overrun_cnt)
);

// File: tb/frame_packer_tb.sv
`timescale 1ns/100ps
module frame_packer_tb;

    localparam int CNT_W = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sample_strobe = 1'b0;
    logic [63:0]  ts_in = '0;
    logic [127:0] ch_in = '0;
    logic         fr_valid;
    logic         fr_ready = 1'b0;
    logic [63:0]  fr_data;
    logic [CNT_W-1:0] overrun_cnt;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    frame_packer #(.LANE_W(16), .TS_W(64), .CNT_W(CNT_W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .sample_strobe (sample_strobe),
        .ts_in         (ts_in),
        .ch_in         (ch_in),
        .fr_valid      (fr_valid),
        .fr_ready      (fr_ready),
        .fr_data       (fr_data),
        .overrun_cnt   (overrun_cnt)
    );

    // Stimulus table: {timestamp, ch7 .. ch0}
    localparam logic [191:0] VEC [6] = '{
        {64'h0000_0000_0000_0001, 128'h0007_0006_0005_0004_0003_0002_0001_0000},
        {64'hF123_4567_89AB_CDEF, 128'h8000_7FFF_FFFF_0001_1234_ABCD_5555_AAAA},
        {64'hFFFF_FFFF_FFFF_FFFF, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF},
        {64'h0000_0000_0000_0000, 128'h0000_0000_0000_0000_0000_0000_0000_0000},
        {64'h0FED_CBA9_8765_4321, 128'hC0DE_BEEF_DEAD_F00D_0BAD_CAFE_FACE_1357},
        {64'hA5A5_5A5A_3C3C_C3C3, 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10}
    };

    function automatic logic [63:0] exp_word(input int k, input logic [63:0] ts,
                                              input logic [127:0] ch);
        case (k)
            0: return {4'h0, ts[59:0]};
            1: return {2'b01, 14'h0, ch[15:0],   ch[31:16],   ch[47:32]};
            2: return {2'b10, 14'h0, ch[63:48],  ch[79:64],   ch[95:80]};
            default: return {2'b11, 14'h0, ch[111:96], ch[127:112], 16'h0};
        endcase
    endfunction

    function automatic string word_req(input int k);
        case (k)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge with a word due on the output. Stalls for 'stall'
    // cycles, checking the word holds, then takes it with a handshake.
    task automatic pull(input int stall, output logic [63:0] w);
        logic [63:0] first;
        first = fr_data;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(fr_valid && fr_data == first, "R6 hold under stall", fr_data, first);
        end
        chk(fr_valid == 1'b1, "R6 word present", 64'(fr_valid), 64'd1);
        w = fr_data;
        fr_ready = 1'b1;
        @(negedge clk);
        fr_ready = 1'b0;
    endtask

    task automatic strobe_in(input logic [63:0] ts, input logic [127:0] ch);
        ts_in = ts;
        ch_in = ch;
        sample_strobe = 1'b1;
        @(negedge clk);
        sample_strobe = 1'b0;
    endtask

    task automatic run_frame(input logic [63:0] ts, input logic [127:0] ch,
                             input int stall);
        logic [63:0] w;
        strobe_in(ts, ch);
        for (int k = 0; k < 4; k++) begin
            pull(stall, w);
            chk(w == exp_word(k, ts, ch), word_req(k), w, exp_word(k, ts, ch));
        end
        chk(fr_valid == 1'b0, "R7 idle after four words", 64'(fr_valid), 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [63:0] w;
        logic [63:0] held;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(fr_valid == 1'b0, "R1 valid after reset", 64'(fr_valid), 64'd0);
        chk(overrun_cnt == '0, "R1 count after reset", 64'(overrun_cnt), 64'd0);

        // Table walk, stall length varies per entry
        for (int i = 0; i < 6; i++) begin
            run_frame(VEC[i][191:128], VEC[i][127:0], i % 3);
            @(negedge clk);
        end

        // R8: inputs change right after the capture
        strobe_in(VEC[4][191:128], VEC[4][127:0]);
        ts_in = VEC[5][191:128];
        ch_in = VEC[5][127:0];
        for (int k = 0; k < 4; k++) begin
            pull(1, w);
            chk(w == exp_word(k, VEC[4][191:128], VEC[4][127:0]), "R8 captured snapshot",
                w, exp_word(k, VEC[4][191:128], VEC[4][127:0]));
        end
        @(negedge clk);

        // R9: strobe mid-frame and on the final handshake
        strobe_in(VEC[1][191:128], VEC[1][127:0]);
        pull(0, w);
        chk(w == exp_word(0, VEC[1][191:128], VEC[1][127:0]), "R2 overrun frame word0",
            w, exp_word(0, VEC[1][191:128], VEC[1][127:0]));
        strobe_in(VEC[2][191:128], VEC[2][127:0]);
        chk(overrun_cnt == 3'd1, "R9 mid-frame drop counted", 64'(overrun_cnt), 64'd1);
        for (int k = 1; k < 3; k++) begin
            pull(0, w);
            chk(w == exp_word(k, VEC[1][191:128], VEC[1][127:0]), "R9 frame unchanged",
                w, exp_word(k, VEC[1][191:128], VEC[1][127:0]));
        end
        w = fr_data;
        chk(w == exp_word(3, VEC[1][191:128], VEC[1][127:0]), "R9 last word unchanged",
            w, exp_word(3, VEC[1][191:128], VEC[1][127:0]));
        fr_ready = 1'b1;
        sample_strobe = 1'b1;
        @(negedge clk);
        fr_ready = 1'b0;
        sample_strobe = 1'b0;
        chk(overrun_cnt == 3'd2, "R9 strobe on final handshake dropped",
            64'(overrun_cnt), 64'd2);
        chk(fr_valid == 1'b0, "R9 no frame from final-handshake strobe",
            64'(fr_valid), 64'd0);

        // R11: strobe in the first idle cycle is accepted
        strobe_in(VEC[3][191:128], VEC[3][127:0]);
        chk(fr_valid == 1'b1, "R11 back-to-back accepted", 64'(fr_valid), 64'd1);
        for (int k = 0; k < 4; k++) begin
            pull(0, w);
            chk(w == exp_word(k, VEC[3][191:128], VEC[3][127:0]), "R11 frame content",
                w, exp_word(k, VEC[3][191:128], VEC[3][127:0]));
        end
        @(negedge clk);

        // R10: saturate the drop counter while the frame is stalled
        strobe_in(VEC[0][191:128], VEC[0][127:0]);
        held = fr_data;
        sample_strobe = 1'b1;
        repeat (8) @(negedge clk);
        sample_strobe = 1'b0;
        chk(overrun_cnt == 3'd7, "R10 saturated count", 64'(overrun_cnt), 64'd7);
        chk(fr_data == held, "R6 word held through strobes", fr_data, held);
        sample_strobe = 1'b1;
        @(negedge clk);
        sample_strobe = 1'b0;
        chk(overrun_cnt == 3'd7, "R10 stays at max", 64'(overrun_cnt), 64'd7);
        for (int k = 0; k < 4; k++) begin
            pull(0, w);
            chk(w == exp_word(k, VEC[0][191:128], VEC[0][127:0]), "R10 frame intact",
                w, exp_word(k, VEC[0][191:128], VEC[0][127:0]));
        end

        // R1: reset in the middle of a frame
        strobe_in(VEC[4][191:128], VEC[4][127:0]);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(fr_valid == 1'b0, "R1 valid after mid-frame reset", 64'(fr_valid), 64'd0);
        chk(overrun_cnt == '0, "R1 count after mid-frame reset", 64'(overrun_cnt), 64'd0);
        @(negedge clk);
        chk(fr_valid == 1'b0, "R7 stays idle without strobe", 64'(fr_valid), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule